// File: doc/BRIEF.md
# Hot-Swap Start-Up Sequencer

This block is the digital sequencer behind a hot-swap power switch. It reads comparator flags from the analog front end: supply lockout, undervoltage, overvoltage, an external reset request, gate-low and gate-high levels, a sense-over-breaker flag and a soft-start-low flag. It also reads a fault-latch input from the current-fault integrator. From these it decides when the pass transistor gate may be driven, when the soft-start ramp may run, and how the timing element is steered. A saturating counter takes the place of the timing capacitor. Its level is visible on a port, and a three-bit mode code shows what the counter is doing.

The sequence runs from supply lockout to an off phase. An initial timing cycle follows, with a slow count up to a high threshold and a fast discharge down to a low threshold. The start permissions are then checked a second time before the gate is released. The block moves to the running phase once the gate reaches its high level. Overvoltage only disconnects the gate and soft-start for as long as it lasts. A latched fault stops the switch and parks the timer at full scale until lockout, undervoltage or reset clears it.

Top module: `hotswap_seq`

## Requirements
- R1: Every comparator flag passes through two flip-flops, so a change on a flag moves the state on the third rising clock edge after it. The fault-latch input is not synchronized.
- R2: While lockout is high, the block sits in its lockout phase. Gate and soft-start enables and power-good are low, the timer mode is 0 (clear) and the timer level is 0. Undervoltage and overvoltage flags have no effect in this phase.
- R3: When lockout is low and either undervoltage or reset is high, the block goes to its off phase from any state. In that phase gate and soft-start are disabled, power-good is low and the timer mode is 0 (clear), which holds the level at 0.
- R4: The off phase moves on to initial timing only when all of these hold: overvoltage, reset and sense flags are low, gate-low and soft-start-low are high, and the timer level is at or below TMR_LO.
- R5: During initial timing the timer mode is 2 (slow up). The level rises by SLOW_STEP each cycle until it reaches TMR_HI, so the mode shows 2 for ceil(TMR_HI/SLOW_STEP)+1 cycles.
- R6: The timer mode then reads 3 (fast down) and the level falls by FAST_STEP per cycle, stopping at 0 at the lowest, until it is at or below TMR_LO. Gate-low, soft-start-low, a clear sense flag and a clear overvoltage flag must then be confirmed again before start-up.
- R7: In start-up, gate and soft-start are enabled with timer mode 1 (hold). A high gate-high flag moves the block to running, where power-good is high.
- R8: Overvoltage in start-up or running drops gate and soft-start but keeps power-good and the timer level. When it clears, start-up resumes without a new initial timing cycle.
- R9: A high fault latch drops the gate enable in the same cycle. The block then enters shutdown with timer mode 4 (latched high), the level at full scale (all ones) and power-good low.
- R10: Shutdown is left only through lockout, undervoltage or reset. Releasing the fault latch has no effect.
- R11: If a fault latch and an overvoltage flag reach the state machine in the same cycle, shutdown takes precedence over the overvoltage disconnect.
- R12: While rst_n is low, all enables and power-good are low, the timer mode is 0 and the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout_a | input | 1 | Supply lockout flag, asynchronous |
| uv_a | input | 1 | Undervoltage flag, asynchronous |
| ov_a | input | 1 | Overvoltage flag, asynchronous |
| reset_a | input | 1 | External reset request, asynchronous |
| gate_low_a | input | 1 | Gate below its low level, asynchronous |
| gate_high_a | input | 1 | Gate above its high level, asynchronous |
| sense_trip_a | input | 1 | Sense above breaker level, asynchronous |
| ss_low_a | input | 1 | Soft-start node near zero, asynchronous |
| fault_latch | input | 1 | Fault integrator has latched, synchronous |
| gate_en | output | 1 | Gate drive enable |
| ss_en | output | 1 | Soft-start ramp enable |
| pgood | output | 1 | Power-good |
| tmr_mode | output | 3 | Timer mode: 0 clear, 1 hold, 2 slow up, 3 fast down, 4 latched high |
| tmr_level | output | TMR_W | Timer counter level |

## Verification
A latched fault and an overvoltage disconnect can both become due at the same clock edge while the switch is running. These two are resolved in opposite ways: shutdown clears power-good, while overvoltage keeps it. To provoke the clash, the bench raises the overvoltage flag and then waits two edges until the flag is through the synchronizer. It raises the fault latch in the following half cycle, so both conditions meet the state machine at one edge. It judges the result at the next sample: power-good must be low and the timer mode must read latched high, which an overvoltage-first design would not show.

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int TMR_W     = 8,
  parameter int TMR_HI    = 200,
  parameter int TMR_LO    = 20,
  parameter int SLOW_STEP = 5,
  parameter int FAST_STEP = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lockout_a,
  input  logic             uv_a,
  input  logic             ov_a,
  input  logic             reset_a,
  input  logic             gate_low_a,
  input  logic             gate_high_a,
  input  logic             sense_trip_a,
  input  logic             ss_low_a,
  input  logic             fault_latch,
  output logic             gate_en,
  output logic             ss_en,
  output logic             pgood,
  output logic [2:0]       tmr_mode,
  output logic [TMR_W-1:0] tmr_level
);

  localparam int NFLAG = 8;
  localparam logic [TMR_W-1:0] T_HI   = TMR_W'(TMR_HI);
  localparam logic [TMR_W-1:0] T_LO   = TMR_W'(TMR_LO);
  localparam logic [TMR_W-1:0] T_SLOW = TMR_W'(SLOW_STEP);
  localparam logic [TMR_W-1:0] T_FAST = TMR_W'(FAST_STEP);

  localparam logic [2:0] M_CLR   = 3'd0;
  localparam logic [2:0] M_HOLD  = 3'd1;
  localparam logic [2:0] M_SLOW  = 3'd2;
  localparam logic [2:0] M_FAST  = 3'd3;
  localparam logic [2:0] M_LATCH = 3'd4;

  typedef enum logic [3:0] {
    S_LOCK, S_OFF, S_INIT, S_DISCH, S_ARM, S_START, S_RUN, S_OVH, S_SHUT
  } phase_t;

  logic [NFLAG-1:0] raw, sync1, sync2;
  logic lock_s, uv_s, ov_s, rst_s, glo_s, ghi_s, sns_s, sslo_s;

  assign raw = {lockout_a, uv_a, ov_a, reset_a, gate_low_a, gate_high_a, sense_trip_a, ss_low_a};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end

  assign {lock_s, uv_s, ov_s, rst_s, glo_s, ghi_s, sns_s, sslo_s} = sync2;

  phase_t state, nxt;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic pg_n;

  wire init_ok = !ov_s && glo_s && !sns_s && sslo_s && (tmr <= T_LO);
  wire arm_ok  = !ov_s && glo_s && !sns_s && sslo_s;

  always_comb begin
    nxt = state;
    if (lock_s)
      nxt = S_LOCK;
    else if (uv_s || rst_s)
      nxt = S_OFF;
    else
      case (state)
        S_LOCK:  nxt = S_OFF;
        S_OFF:   if (init_ok) nxt = S_INIT;
        S_INIT:  if (tmr >= T_HI) nxt = S_DISCH;
        S_DISCH: if (tmr <= T_LO) nxt = S_ARM;
        S_ARM:   if (arm_ok) nxt = S_START;
        S_START: if (fault_latch) nxt = S_SHUT;
                 else if (ov_s) nxt = S_OVH;
                 else if (ghi_s) nxt = S_RUN;
        S_RUN:   if (fault_latch) nxt = S_SHUT;
                 else if (ov_s) nxt = S_OVH;
        S_OVH:   if (fault_latch) nxt = S_SHUT;
                 else if (!ov_s) nxt = S_START;
        S_SHUT:  nxt = S_SHUT;
        default: nxt = S_LOCK;
      endcase
  end

  logic [TMR_W:0]   up_sum;
  logic [TMR_W-1:0] up_sat, dn_sat;
  assign up_sum = {1'b0, tmr} + {1'b0, T_SLOW};
  assign up_sat = up_sum[TMR_W] ? '1 : up_sum[TMR_W-1:0];
  assign dn_sat = (tmr > T_FAST) ? tmr - T_FAST : '0;

  always_comb begin
    case (state)
      S_LOCK, S_OFF: tmr_n = '0;
      S_INIT:        tmr_n = (tmr >= T_HI) ? tmr : up_sat;
      S_DISCH:       tmr_n = (tmr <= T_LO) ? tmr : dn_sat;
      S_SHUT:        tmr_n = '1;
      default:       tmr_n = tmr;
    endcase
  end

  always_comb begin
    case (nxt)
      S_RUN:          pg_n = 1'b1;
      S_START, S_OVH: pg_n = pgood;
      default:        pg_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_LOCK;
      tmr   <= '0;
      pgood <= 1'b0;
    end else begin
      state <= nxt;
      tmr   <= tmr_n;
      pgood <= pg_n;
    end

  wire driving = (state == S_START) || (state == S_RUN);
  assign ss_en     = driving;
  assign gate_en   = driving && !fault_latch;
  assign tmr_level = tmr;

  always_comb begin
    case (state)
      S_LOCK, S_OFF: tmr_mode = M_CLR;
      S_INIT:        tmr_mode = M_SLOW;
      S_DISCH:       tmr_mode = M_FAST;
      S_SHUT:        tmr_mode = M_LATCH;
      default:       tmr_mode = M_HOLD;
    endcase
  end

  wire quiet = !lock_s && !uv_s && !rst_s;

  assert_lockout_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> (!gate_en && !ss_en && !pgood && tmr_mode == M_CLR));

  assert_uv_shutdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_s && !lock_s) |=> (tmr_mode == M_CLR && !ss_en && !pgood));

  assert_ov_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && ov_s && !fault_latch && quiet) |=> (!ss_en && pgood && $stable(tmr_level)));

  assert_fault_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latch && ss_en && quiet) |=> (tmr_mode == M_LATCH && !pgood));

  assert_shut_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHUT && quiet) |=> (state == S_SHUT && !gate_en));

  assert_init_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_mode == M_SLOW && tmr_level >= T_HI) |=> (tmr_mode == M_FAST));

endmodule

// File: tb/test_hotswap_seq.sv
`timescale 1ns/1ps
module test_hotswap_seq;
  localparam int TMR_W = 8, T_HI = 200, T_LO = 20, T_SLOW = 5, T_FAST = 30;

  logic clk = 0, rst_n = 0;
  logic lockout_a, uv_a, ov_a, reset_a, gate_low_a, gate_high_a, sense_trip_a, ss_low_a, fault_latch;
  logic gate_en, ss_en, pgood;
  logic [2:0] tmr_mode;
  logic [TMR_W-1:0] tmr_level;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hotswap_seq #(.TMR_W(TMR_W), .TMR_HI(T_HI), .TMR_LO(T_LO), .SLOW_STEP(T_SLOW), .FAST_STEP(T_FAST)) i_hotswap_seq (
    .clk(clk), .rst_n(rst_n), .lockout_a(lockout_a), .uv_a(uv_a), .ov_a(ov_a), .reset_a(reset_a),
    .gate_low_a(gate_low_a), .gate_high_a(gate_high_a), .sense_trip_a(sense_trip_a), .ss_low_a(ss_low_a),
    .fault_latch(fault_latch), .gate_en(gate_en), .ss_en(ss_en), .pgood(pgood),
    .tmr_mode(tmr_mode), .tmr_level(tmr_level));

  // inputs {lock,uv,ov,rst,glo,ghi,sns,sslo,flt} | hold cycles | {gate,ss,pg,mode}
  localparam logic [22:0] VEC [0:13] = '{
    {9'b100010010, 8'd8,  6'b000000},
    {9'b110010010, 8'd8,  6'b000000},
    {9'b010010010, 8'd8,  6'b000000},
    {9'b000010010, 8'd80, 6'b110001},
    {9'b000001010, 8'd8,  6'b111001},
    {9'b001001010, 8'd8,  6'b001001},
    {9'b000001010, 8'd8,  6'b111001},
    {9'b000001011, 8'd8,  6'b000100},
    {9'b000001010, 8'd8,  6'b000100},
    {9'b000101010, 8'd8,  6'b000000},
    {9'b000001010, 8'd8,  6'b000000},
    {9'b000010110, 8'd8,  6'b000000},
    {9'b000010010, 8'd80, 6'b110001},
    {9'b010010010, 8'd8,  6'b000000}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:    return "R2";
      2, 9:    return "R3";
      3, 12:   return "R7";
      4:       return "R7";
      5, 6:    return "R8";
      7:       return "R9";
      8:       return "R10";
      10, 11:  return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {lockout_a, uv_a, ov_a, reset_a, gate_low_a, gate_high_a, sense_trip_a, ss_low_a, fault_latch} = v;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_run();
    rst_n = 0;
    drive(9'b000010010);
    cyc(3);
    rst_n = 1;
    cyc(80);
    drive(9'b000001010);
    cyc(8);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    drive(9'b100010010);
    cyc(3);
    // R12 reset state
    check({gate_en, ss_en, pgood, tmr_mode} == 6'b0 && tmr_level == 0, "R12",
          {gate_en, ss_en, pgood, tmr_mode}, 0);
    rst_n = 1;

    for (int i = 0; i < 14; i++) begin
      logic [5:0] got;
      drive(VEC[i][22:14]);
      cyc(int'(VEC[i][13:6]));
      got = {gate_en, ss_en, pgood, tmr_mode};
      check(got == VEC[i][5:0], tag_of(i), got, VEC[i][5:0]);
    end

    // R5, R6: initial timing profile
    begin
      int slow_cnt = 0, peak = 0, lvl, exp_slow, n = 0;
      rst_n = 0;
      drive(9'b000010010);
      cyc(2);
      rst_n = 1;
      while (!ss_en && n < 400) begin
        @(negedge clk);
        n++;
        if (tmr_mode == 3'd2) slow_cnt++;
        if (int'(tmr_level) > peak) peak = int'(tmr_level);
      end
      exp_slow = (T_HI + T_SLOW - 1) / T_SLOW + 1;
      check(slow_cnt == exp_slow, "R5", slow_cnt, exp_slow);
      lvl = ((T_HI + T_SLOW - 1) / T_SLOW) * T_SLOW;
      check(peak == lvl, "R5", peak, lvl);
      while (lvl > T_LO) lvl = (lvl > T_FAST) ? lvl - T_FAST : 0;
      check(int'(tmr_level) == lvl, "R6", tmr_level, lvl);
    end

    // R6: recheck after discharge blocks start while sense is tripped
    begin
      int n = 0;
      rst_n = 0;
      drive(9'b000010010);
      cyc(2);
      rst_n = 1;
      while (tmr_mode != 3'd3 && n < 400) begin @(negedge clk); n++; end
      drive(9'b000010110);
      cyc(20);
      check(tmr_mode == 3'd1 && !ss_en, "R6", {ss_en, tmr_mode}, 1);
      drive(9'b000010010);
      cyc(4);
      check(ss_en == 1'b1, "R6", ss_en, 1);
    end

    // R1, R8: resume after overvoltage, exactly three edges, no new timing
    begin
      int n = 0;
      bit saw_slow = 0;
      logic [TMR_W-1:0] lvl0;
      go_run();
      lvl0 = tmr_level;
      drive(9'b001001010);
      cyc(8);
      check(pgood && tmr_level == lvl0, "R8", tmr_level, lvl0);
      drive(9'b000001010);
      while (!gate_en && n < 20) begin
        @(negedge clk);
        n++;
        if (tmr_mode == 3'd2) saw_slow = 1;
      end
      check(n == 3, "R1", n, 3);
      check(!saw_slow && pgood, "R8", saw_slow, 0);
    end

    // R9: gate drops within the same cycle as the fault latch
    go_run();
    drive(9'b000001011);
    #1;
    check(gate_en == 1'b0 && ss_en == 1'b1, "R9", {gate_en, ss_en}, 1);
    @(negedge clk);
    check(tmr_mode == 3'd4 && !pgood, "R9", tmr_mode, 4);
    @(negedge clk);
    check(tmr_level == {TMR_W{1'b1}}, "R9", tmr_level, (1 << TMR_W) - 1);
    drive(9'b000001010);
    cyc(10);
    check(tmr_mode == 3'd4, "R10", tmr_mode, 4);
    drive(9'b100001010);
    cyc(5);
    check(tmr_mode == 3'd0 && tmr_level == 0, "R10", tmr_mode, 0);

    // R11: fault latch and overvoltage meet the FSM at one edge
    go_run();
    drive(9'b001001010);
    cyc(2);
    drive(9'b001001011);
    @(negedge clk);
    check(tmr_mode == 3'd4 && !pgood && !ss_en, "R11", {pgood, tmr_mode}, 4);
    drive(9'b000001010);
    cyc(10);
    check(tmr_mode == 3'd4 && !gate_en, "R11", tmr_mode, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule